// File: doc/BRIEF.md
# Converter Mode and Reset Controller

This block sequences the operating modes of a multichannel data converter. It merges three reset sources into one reset sequence: a power-on reset, an active-low pin that serves as both sync and reset, and a reset command word taken from a fixed-length host frame. After a reset, the block goes through a current-detect phase. It then runs in continuous conversion or global-chop mode, and it can be parked in standby and woken again.

The block drives a data-ready line. The rising edge of that line tells the host that the interface may be used. Host requests are gated by the same ready state, so any traffic before that edge is dropped. The pin's synchronized low time decides its meaning. A short low pulse gives a one-cycle sync strobe. A low pulse longer than a threshold holds the block in reset until the pin goes high again. The frame shifter, the CRC and the analog path are outside the block. Frame completion and the decoded command word arrive as plain inputs.

Top module: `cvt_mode_ctrl`

## Requirements
- R1: After `por_n` is released, `drdy` stays low and `mode` stays RESET for `POR_CYCLES` rising clock edges. On the next edge, `drdy` goes high and `mode` becomes DETECT.
- R2: `host_ok` is high only when `host_req` is high and `drdy` is high. A request made before ready is dropped.
- R3: When the synchronized pin has been low for more than `RST_WIDTH` cycles, the block enters RESET with `drdy` low. It stays there for as long as the pin is held low, and no sync strobe is produced.
- R4: After the pin returns high, the block leaves RESET for DETECT and `drdy` rises again.
- R5: A low pulse on `sync_rst_n` of at most `RST_WIDTH` cycles produces exactly one one-cycle `sync_strobe`. It leaves `mode` unchanged and `drdy` high.
- R6: The reset command is the word 16'h0011 on `cmd_word` while `frame_done` is high. It puts the block in RESET at the next edge and in DETECT one edge later. The same word without `frame_done`, or any other word with `frame_done`, has no effect.
- R7: `cfg_reset`, which returns the configuration to defaults, is high exactly while `mode` is RESET.
- R8: In DETECT, `detect_done` moves the block to GCHOP when `chop_en` is 1 and to CONT when it is 0. Without `detect_done`, the block stays in DETECT.
- R9: `standby_cmd` moves CONT or GCHOP to STBY, and it wins over a change of `chop_en` in the same cycle. In STBY, `wakeup_cmd` moves to GCHOP when `chop_en` is 1 and to CONT when it is 0. `chop_en` alone has no effect in STBY.
- R10: In CONT, `chop_en` = 1 moves the block to GCHOP. In GCHOP, `chop_en` = 0 moves it back to CONT. `detect_done` has no effect in either mode.
- R11: `mode` is encoded as RESET=0, DETECT=1, CONT=2, GCHOP=3, STBY=4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| sync_rst_n | input | 1 | Sync/reset pin, active low, asynchronous to clk |
| frame_done | input | 1 | High for one cycle when a host frame completes |
| cmd_word | input | 16 | First command word of the completed frame |
| standby_cmd | input | 1 | Standby request |
| wakeup_cmd | input | 1 | Wakeup request |
| chop_en | input | 1 | Global-chop enable |
| detect_done | input | 1 | Current detection finished |
| host_req | input | 1 | Host transaction request |
| host_ok | output | 1 | Host transaction accepted |
| drdy | output | 1 | Data-ready / interface-ready line |
| sync_strobe | output | 1 | One-cycle pulse for a short sync pulse |
| cfg_reset | output | 1 | Configuration reset to defaults |
| mode | output | 3 | Current operating mode (R11 encoding) |

## Verification
The hardest case to reach is the boundary of the pin's low time. A pulse of exactly `RST_WIDTH` cycles must give a sync strobe, and one cycle more must give a reset. Two synchronizer flops sit between the pin and the low-time counter. The stimulus therefore drives the pin low for a counted number of negative clock edges at both lengths. It then scans `sync_strobe`, `drdy` and `mode` on every cycle of a window afterwards, rather than at one fixed instant. A long hold shows that reset lasts as long as the pin is low. The command path is exercised with the right word at the wrong time, and with the wrong word at the right time.

// File: rtl/cvt_mode_pkg.sv
package cvt_mode_pkg;
  typedef enum logic [2:0] {
    MODE_RESET  = 3'd0,
    MODE_DETECT = 3'd1,
    MODE_CONT   = 3'd2,
    MODE_GCHOP  = 3'd3,
    MODE_STBY   = 3'd4
  } mode_t;

  localparam logic [15:0] CMD_RESET_WORD = 16'h0011;

  function automatic logic is_reset_cmd(logic done, logic [15:0] word);
    return done && (word == CMD_RESET_WORD);
  endfunction

  function automatic mode_t conv_mode(logic chop);
    return chop ? MODE_GCHOP : MODE_CONT;
  endfunction
endpackage

// File: rtl/cvt_pin_filter.sv
module cvt_pin_filter #(
  parameter int RST_WIDTH = 8
) (
  input  logic clk,
  input  logic por_n,
  input  logic pin_n,
  output logic pin_rst,
  output logic sync_strobe
);
  localparam int CW = $clog2(RST_WIDTH + 2);
  localparam logic [CW-1:0] W_C   = CW'(RST_WIDTH);
  localparam logic [CW-1:0] LIM_C = CW'(RST_WIDTH + 1);

  logic ff1, ff2;
  logic [CW-1:0] low_cnt;

  function automatic logic [CW-1:0] low_next(logic [CW-1:0] c);
    return (c == LIM_C) ? c : c + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      ff1 <= 1'b1;
      ff2 <= 1'b1;
      low_cnt <= '0;
    end else begin
      ff1 <= pin_n;
      ff2 <= ff1;
      if (!ff2) low_cnt <= low_next(low_cnt);
      else      low_cnt <= '0;
    end
  end

  assign pin_rst     = !ff2 && (low_cnt >= W_C);
  assign sync_strobe = ff2 && (low_cnt != '0) && (low_cnt <= W_C);

  assert_strobe_single_R5: assert property (@(posedge clk) disable iff (!por_n)
    sync_strobe |=> !sync_strobe);
  assert_strobe_not_reset_R3: assert property (@(posedge clk) disable iff (!por_n)
    pin_rst |=> !sync_strobe);
endmodule

// File: rtl/cvt_por_timer.sv
module cvt_por_timer #(
  parameter int POR_CYCLES = 20
) (
  input  logic clk,
  input  logic por_n,
  output logic por_busy
);
  localparam int PW = $clog2(POR_CYCLES + 1);
  localparam logic [PW-1:0] END_C = PW'(POR_CYCLES);

  logic [PW-1:0] cnt;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)            cnt <= '0;
    else if (cnt != END_C) cnt <= cnt + 1'b1;
  end

  assign por_busy = (cnt != END_C);

  assert_por_done_sticky_R1: assert property (@(posedge clk) disable iff (!por_n)
    !por_busy |=> !por_busy);
endmodule

// File: rtl/cvt_mode_fsm.sv
module cvt_mode_fsm
  import cvt_mode_pkg::*;
(
  input  logic  clk,
  input  logic  por_n,
  input  logic  hold_rst,
  input  logic  detect_done,
  input  logic  standby_cmd,
  input  logic  wakeup_cmd,
  input  logic  chop_en,
  output mode_t mode,
  output logic  rdy
);
  mode_t mode_nx;

  always_comb begin
    mode_nx = mode;
    unique case (mode)
      MODE_RESET:  mode_nx = MODE_DETECT;
      MODE_DETECT: if (detect_done) mode_nx = conv_mode(chop_en);
      MODE_CONT:   if (standby_cmd) mode_nx = MODE_STBY;
                   else if (chop_en) mode_nx = MODE_GCHOP;
      MODE_GCHOP:  if (standby_cmd) mode_nx = MODE_STBY;
                   else if (!chop_en) mode_nx = MODE_CONT;
      MODE_STBY:   if (wakeup_cmd) mode_nx = conv_mode(chop_en);
      default:     mode_nx = MODE_RESET;
    endcase
    if (hold_rst) mode_nx = MODE_RESET;
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      mode <= MODE_RESET;
      rdy  <= 1'b0;
    end else begin
      mode <= mode_nx;
      if (hold_rst)                rdy <= 1'b0;
      else if (mode == MODE_RESET) rdy <= 1'b1;
    end
  end

  assert_detect_after_reset_R4: assert property (@(posedge clk) disable iff (!por_n)
    (mode == MODE_RESET && !hold_rst) |=> (mode == MODE_DETECT && rdy));
  assert_standby_entry_R9: assert property (@(posedge clk) disable iff (!por_n)
    ((mode == MODE_CONT || mode == MODE_GCHOP) && standby_cmd && !hold_rst) |=> mode == MODE_STBY);
  assert_ready_rises_from_reset_R1: assert property (@(posedge clk) disable iff (!por_n)
    $rose(rdy) |-> $past(mode) == MODE_RESET);
  assert_reset_drops_ready_R3: assert property (@(posedge clk) disable iff (!por_n)
    hold_rst |=> (!rdy && mode == MODE_RESET));
endmodule

// File: rtl/cvt_mode_ctrl.sv
module cvt_mode_ctrl
  import cvt_mode_pkg::*;
#(
  parameter int POR_CYCLES = 20,
  parameter int RST_WIDTH  = 8
) (
  input  logic        clk,
  input  logic        por_n,
  input  logic        sync_rst_n,
  input  logic        frame_done,
  input  logic [15:0] cmd_word,
  input  logic        standby_cmd,
  input  logic        wakeup_cmd,
  input  logic        chop_en,
  input  logic        detect_done,
  input  logic        host_req,
  output logic        host_ok,
  output logic        drdy,
  output logic        sync_strobe,
  output logic        cfg_reset,
  output logic [2:0]  mode
);
  logic  por_busy, pin_rst, cmd_rst, hold_rst, rdy;
  mode_t mode_q;

  cvt_por_timer #(.POR_CYCLES(POR_CYCLES)) u_por (
    .clk(clk), .por_n(por_n), .por_busy(por_busy));

  cvt_pin_filter #(.RST_WIDTH(RST_WIDTH)) u_pin (
    .clk(clk), .por_n(por_n), .pin_n(sync_rst_n),
    .pin_rst(pin_rst), .sync_strobe(sync_strobe));

  assign cmd_rst  = is_reset_cmd(frame_done, cmd_word);
  assign hold_rst = por_busy | pin_rst | cmd_rst;

  cvt_mode_fsm u_fsm (
    .clk(clk), .por_n(por_n), .hold_rst(hold_rst),
    .detect_done(detect_done), .standby_cmd(standby_cmd),
    .wakeup_cmd(wakeup_cmd), .chop_en(chop_en),
    .mode(mode_q), .rdy(rdy));

  assign mode      = mode_q;
  assign drdy      = rdy;
  assign cfg_reset = (mode_q == MODE_RESET);
  assign host_ok   = host_req & rdy;

  assert_cmd_reset_R6: assert property (@(posedge clk) disable iff (!por_n)
    (frame_done && cmd_word == 16'h0011) |=> (mode == 3'd0 && !drdy));
  assert_cfg_reset_R7: assert property (@(posedge clk) disable iff (!por_n)
    $fell(cfg_reset) |-> $rose(drdy));
endmodule

// File: tb/tb_cvt_mode_ctrl.sv
module tb_cvt_mode_ctrl;
  localparam int P = 20;
  localparam int W = 8;

  logic clk = 0, por_n = 0, sync_rst_n = 1, frame_done = 0;
  logic [15:0] cmd_word = 0;
  logic standby_cmd = 0, wakeup_cmd = 0, chop_en = 0, detect_done = 0, host_req = 0;
  logic host_ok, drdy, sync_strobe, cfg_reset;
  logic [2:0] mode;
  int tests = 0, fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  cvt_mode_ctrl #(.POR_CYCLES(P), .RST_WIDTH(W)) dut (
    .clk(clk), .por_n(por_n), .sync_rst_n(sync_rst_n), .frame_done(frame_done),
    .cmd_word(cmd_word), .standby_cmd(standby_cmd), .wakeup_cmd(wakeup_cmd),
    .chop_en(chop_en), .detect_done(detect_done), .host_req(host_req),
    .host_ok(host_ok), .drdy(drdy), .sync_strobe(sync_strobe),
    .cfg_reset(cfg_reset), .mode(mode));

  task automatic chk(string req, int got, int exp);
    tests++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  // {standby, wakeup, chop, detect_done, expected mode}
  localparam logic [6:0] VEC [14] = '{
    {4'b0000, 3'd1},  // R8 stays in DETECT
    {4'b0001, 3'd2},  // R8 detect, chop 0 -> CONT
    {4'b0010, 3'd3},  // R10 CONT chop -> GCHOP
    {4'b0011, 3'd3},  // R10 detect ignored in GCHOP
    {4'b0000, 3'd2},  // R10 GCHOP no chop -> CONT
    {4'b0001, 3'd2},  // R10 detect ignored in CONT
    {4'b1000, 3'd4},  // R9 standby from CONT
    {4'b0010, 3'd4},  // R9 chop ignored in STBY
    {4'b0110, 3'd3},  // R9 wakeup chop 1 -> GCHOP
    {4'b1010, 3'd4},  // R9 standby from GCHOP
    {4'b0100, 3'd2},  // R9 wakeup chop 0 -> CONT
    {4'b1010, 3'd4},  // R9 standby wins over chop in CONT
    {4'b0100, 3'd2},  // R9 wakeup -> CONT
    {4'b0000, 3'd2}   // R11 CONT holds encoding 2
  };

  task automatic pin_pulse(int len, output int strobes, output int min_drdy, output int saw_reset);
    strobes = 0; min_drdy = 1; saw_reset = 0;
    sync_rst_n = 0;
    for (int i = 0; i < len + 12; i++) begin
      if (i == len) sync_rst_n = 1;
      @(negedge clk);
      strobes += int'(sync_strobe);
      if (!drdy) min_drdy = 0;
      if (mode == 3'd0) saw_reset = 1;
    end
  endtask

  initial begin
    int s, md, sr;
    repeat (3) @(negedge clk);
    host_req = 1;
    chk("R1 reset mode", int'(mode), 0);
    chk("R1 reset drdy", int'(drdy), 0);
    chk("R7 cfg_reset in reset", int'(cfg_reset), 1);
    por_n = 1;
    repeat (P) @(negedge clk);
    chk("R1 drdy low before delay", int'(drdy), 0);
    chk("R2 host blocked before ready", int'(host_ok), 0);
    @(negedge clk);
    chk("R1 drdy high after delay", int'(drdy), 1);
    chk("R1 mode DETECT", int'(mode), 1);
    chk("R2 host accepted", int'(host_ok), 1);
    chk("R7 cfg_reset cleared", int'(cfg_reset), 0);
    host_req = 0;
    @(negedge clk);
    chk("R2 no request no accept", int'(host_ok), 0);

    for (int i = 0; i < 14; i++) begin
      {standby_cmd, wakeup_cmd, chop_en, detect_done} = VEC[i][6:3];
      @(negedge clk);
      chk($sformatf("R8/R9/R10 vector %0d", i), int'(mode), int'(VEC[i][2:0]));
    end
    {standby_cmd, wakeup_cmd, chop_en, detect_done} = 4'b0000;

    // R6 ignored command forms (state CONT)
    cmd_word = 16'h0011; frame_done = 0;
    @(negedge clk);
    chk("R6 word without frame ignored", int'(mode), 2);
    cmd_word = 16'h0012; frame_done = 1;
    @(negedge clk);
    chk("R6 other word ignored", int'(mode), 2);
    chk("R6 other word drdy", int'(drdy), 1);
    cmd_word = 16'h0011;
    @(negedge clk);
    frame_done = 0; cmd_word = 0;
    chk("R6 command reset mode", int'(mode), 0);
    chk("R6 command reset drdy", int'(drdy), 0);
    chk("R7 cfg_reset on command", int'(cfg_reset), 1);
    @(negedge clk);
    chk("R6 detect after command", int'(mode), 1);
    chk("R6 drdy back", int'(drdy), 1);
    chop_en = 1; detect_done = 1;
    @(negedge clk);
    detect_done = 0;
    chk("R8 detect chop 1 -> GCHOP", int'(mode), 3);
    chop_en = 0;
    @(negedge clk);
    chk("R10 back to CONT", int'(mode), 2);

    // R5 short pulse of exactly W cycles
    pin_pulse(W, s, md, sr);
    chk("R5 one sync strobe", s, 1);
    chk("R5 drdy stays high", md, 1);
    chk("R5 no reset", sr, 0);
    chk("R5 mode unchanged", int'(mode), 2);

    // R3 boundary W+1 cycles
    pin_pulse(W + 1, s, md, sr);
    chk("R3 boundary no strobe", s, 0);
    chk("R3 boundary drdy dropped", md, 0);
    chk("R3 boundary reset seen", sr, 1);
    chk("R4 boundary back in DETECT", int'(mode), 1);
    chk("R4 boundary drdy high", int'(drdy), 1);

    // R3/R4 long hold
    sync_rst_n = 0;
    repeat (3 * W) @(negedge clk);
    chk("R3 long hold mode", int'(mode), 0);
    chk("R3 long hold drdy", int'(drdy), 0);
    chk("R7 cfg_reset during pin reset", int'(cfg_reset), 1);
    repeat (2 * W) @(negedge clk);
    chk("R3 still reset while low", int'(mode), 0);
    sync_rst_n = 1;
    repeat (5) @(negedge clk);
    chk("R4 detect after release", int'(mode), 1);
    chk("R4 drdy after release", int'(drdy), 1);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: got 0 expected 1");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule